// File: doc/BRIEF.md
# MAC Statistics Counter Bank

This block keeps the per-direction traffic statistics of an Ethernet MAC as a bank of wide counters that software reads and writes over a simple word-addressed register bus. The MAC hands it one pulse per finished frame in each direction. The pulse carries the frame length, the destination class (unicast, multicast, broadcast or none) and the error and event flags of that frame. From each pulse the bank updates several counters at once: all frames, good frames, good-frame octets, the destination class, and one size bin. It also updates one counter for each flag that is raised.

Each counter also feeds an interrupt status bit, which is set when the counter's top bit rises. There is one status and one enable register per direction, and a single interrupt line combines them. A control register holds a self-clearing bit that zeroes every counter of both directions at once. Read data is combinational from the bus address. A write or a frame event takes effect at the clock edge that samples it, so the result is on the read port from the next cycle.

Top module: `stat_counter_bank`

## Requirements
- R1: The control register (word address 0) resets to 0x0000000A. Bits 31..1 are plain read/write. Bit 0 always reads 0.
- R2: Writing a word with bit 0 set to address 0 zeroes every receive and transmit counter at that clock edge. An increment due at the same edge is lost.
- R3: Every counter can be written through the bus, receive counter k at 0x20+k and transmit counter k at 0x40+k. A write beats an increment of the same counter at the same edge, and the other counters of that frame still increment.
- R4: Counters wrap from 0xFFFFFFFF to 0.
- R5: Counter index layout for both directions: 0 good, 1 good octets (adds the length), 2 unicast, 3 multicast, 4 broadcast, 5 all frames, 6..11 size bins, 12 and up one counter per flag. The class field is 0 unicast, 1 multicast, 2 broadcast, 3 none. Only good frames feed counters 0..4 and the bins. Every event feeds counter 5.
- R6: The size bins count good frames with lengths of exactly 64 (index 6), 65..127 (7), 128..255 (8), 256..511 (9), 512..1023 (10) and 1024 or more (11). Frames shorter than 64 fall in no bin.
- R7: The receive port has one flag, a frame check error, at counter 12, and that flag makes a frame bad. The transmit port has seven flags at counters 12..18: bit 0 single collision, 1 multiple collisions, 2 late collision, 3 excess collisions, 4 deferral, 5 underrun, 6 abort. Bits 2, 3, 5 and 6 make a frame bad.
- R8: Status bit k of a direction (receive at 0x01, transmit at 0x03) is set when counter k's bit 31 goes from 0 to 1. Writing 1 to a status bit clears it, writing 0 leaves it unchanged, and a set beats a clear at the same edge.
- R9: The enable registers (receive at 0x02, transmit at 0x04) are plain read/write. The interrupt output is high exactly when some status bit has its enable bit set.
- R10: A read of an address that maps to no register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Word address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rx_evt | input | 1 | One-cycle end-of-frame pulse, receive |
| rx_len | input | 16 | Receive frame length in bytes |
| rx_cast | input | 2 | Receive destination class |
| rx_fcs_err | input | 1 | Receive frame check error |
| tx_evt | input | 1 | One-cycle end-of-frame pulse, transmit |
| tx_len | input | 16 | Transmit frame length in bytes |
| tx_cast | input | 2 | Transmit destination class |
| tx_flags | input | 7 | Transmit event flags |
| irq | output | 1 | Counter interrupt |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. A counter, the control register, a status bit or an enable bit is updated at the edge that samples the write or the frame pulse, and then shows up at once on the combinational read port and on the interrupt line. The bench drives each write and each pulse for a single cycle between falling edges. It samples the read data at the falling edge that follows the sampling rising edge, so each check looks at the first cycle in which the new value is due. Simultaneous cases, such as a write together with an event or a clear together with an event, are driven in the same cycle so that the priority rules decide the value.

// File: rtl/stat_pkg.sv
package stat_pkg;
   localparam int IDX_GOOD    = 0;
   localparam int IDX_OCTET   = 1;
   localparam int IDX_UNI     = 2;
   localparam int IDX_MULTI   = 3;
   localparam int IDX_BCAST   = 4;
   localparam int IDX_ALL     = 5;
   localparam int IDX_BIN64   = 6;
   localparam int IDX_BIN127  = 7;
   localparam int IDX_BIN255  = 8;
   localparam int IDX_BIN511  = 9;
   localparam int IDX_BIN1023 = 10;
   localparam int IDX_BINBIG  = 11;
   localparam int NUM_COMMON  = 12;

   localparam int RX_FLAGS = 1;
   localparam int TX_FLAGS = 7;
   localparam logic [RX_FLAGS-1:0] RX_BAD_MASK = 1'b1;
   localparam logic [TX_FLAGS-1:0] TX_BAD_MASK = 7'b1101100;

   typedef enum logic [1:0] {
      CAST_UNI   = 2'd0,
      CAST_MULTI = 2'd1,
      CAST_BCAST = 2'd2,
      CAST_NONE  = 2'd3
   } cast_e;
endpackage

// File: rtl/stat_event_decode.sv
module stat_event_decode #(
   parameter int LEN_W = 16,
   parameter int NFLAG = 1,
   parameter logic [NFLAG-1:0] BAD_MASK = '1,
   localparam int N = stat_pkg::NUM_COMMON + NFLAG
) (
   input  logic             evt,
   input  logic [LEN_W-1:0] len,
   input  logic [1:0]       cast,
   input  logic [NFLAG-1:0] flags,
   output logic [N-1:0]     inc
);
   import stat_pkg::*;

   logic good;
   assign good = evt & ~|(flags & BAD_MASK);

   always_comb begin
      inc[NUM_COMMON-1:0] = '0;
      inc[IDX_ALL]   = evt;
      inc[IDX_GOOD]  = good;
      inc[IDX_OCTET] = good & (len != '0);
      inc[IDX_UNI]   = good & (cast == CAST_UNI);
      inc[IDX_MULTI] = good & (cast == CAST_MULTI);
      inc[IDX_BCAST] = good & (cast == CAST_BCAST);
      if (good) begin
         if (len == LEN_W'(64))        inc[IDX_BIN64]   = 1'b1;
         else if (len < LEN_W'(64))    inc[IDX_BIN64]   = 1'b0;
         else if (len < LEN_W'(128))   inc[IDX_BIN127]  = 1'b1;
         else if (len < LEN_W'(256))   inc[IDX_BIN255]  = 1'b1;
         else if (len < LEN_W'(512))   inc[IDX_BIN511]  = 1'b1;
         else if (len < LEN_W'(1024))  inc[IDX_BIN1023] = 1'b1;
         else                          inc[IDX_BINBIG]  = 1'b1;
      end
   end

   for (genvar k = 0; k < NFLAG; k++) begin : g_flag
      assign inc[NUM_COMMON+k] = evt & flags[k];
   end
endmodule

// File: rtl/stat_counter.sv
module stat_counter #(
   parameter int CNT_W = 32,
   parameter int AMT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             inc,
   input  logic [AMT_W-1:0] amt,
   output logic [CNT_W-1:0] cnt,
   output logic             msb_rise
);
   logic [CNT_W-1:0] nxt;

   always_comb begin
      if (wr)        nxt = wdata;
      else if (clr)  nxt = '0;
      else if (inc)  nxt = cnt + CNT_W'(amt);
      else           nxt = cnt;
   end

   assign msb_rise = ~cnt[CNT_W-1] & nxt[CNT_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= nxt;
   end
endmodule

// File: rtl/stat_irq_reg.sv
module stat_irq_reg #(
   parameter int N = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         wr_st,
   input  logic         wr_en,
   input  logic [N-1:0] wdata,
   output logic [N-1:0] st,
   output logic [N-1:0] en,
   output logic         irq
);
   logic [N-1:0] clr_mask;
   assign clr_mask = wr_st ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= '0;
         en <= '0;
      end else begin
         st <= (st & ~clr_mask) | set;
         if (wr_en) en <= wdata;
      end
   end

   assign irq = |(st & en);
endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank #(
   parameter int CNT_W  = 32,
   parameter int LEN_W  = 16,
   parameter int ADDR_W = 8,
   parameter int RX_BASE = 32,
   parameter int TX_BASE = 64,
   parameter logic [CNT_W-1:0] CTRL_RST = CNT_W'(32'hA)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   input  logic              rx_evt,
   input  logic [LEN_W-1:0]  rx_len,
   input  logic [1:0]        rx_cast,
   input  logic              rx_fcs_err,
   input  logic              tx_evt,
   input  logic [LEN_W-1:0]  tx_len,
   input  logic [1:0]        tx_cast,
   input  logic [6:0]        tx_flags,
   output logic              irq
);
   import stat_pkg::*;

   localparam int RX_N = NUM_COMMON + RX_FLAGS;
   localparam int TX_N = NUM_COMMON + TX_FLAGS;
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_RX_ST = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_RX_EN = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_TX_ST = ADDR_W'(3);
   localparam logic [ADDR_W-1:0] A_TX_EN = ADDR_W'(4);

   if (CNT_W < TX_N || CNT_W < 4) begin : g_bad_cnt_w
      $error("CNT_W too narrow for the status registers");
   end
   if (LEN_W < 11 || LEN_W > CNT_W) begin : g_bad_len_w
      $error("LEN_W must hold 1024 and fit in a counter");
   end
   if (RX_BASE < 5 || RX_BASE + RX_N > TX_BASE || TX_BASE + TX_N > (1 << ADDR_W)) begin : g_bad_map
      $error("counter windows overlap or exceed the address space");
   end

   logic [CNT_W-1:0] ctrl_q;
   logic             clr_all;
   logic [RX_N-1:0]  rx_inc, rx_rise, rx_st, rx_en;
   logic [TX_N-1:0]  tx_inc, tx_rise, tx_st, tx_en;
   logic [RX_N-1:0][CNT_W-1:0] rx_cnt;
   logic [TX_N-1:0][CNT_W-1:0] tx_cnt;
   logic             rx_irq, tx_irq;

   // control register: bit 0 is a clear-all strobe and is never stored
   assign clr_all = bus_wr && (bus_addr == A_CTRL) && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              ctrl_q <= CTRL_RST & ~CNT_W'(1);
      else if (bus_wr && bus_addr == A_CTRL)   ctrl_q <= bus_wdata & ~CNT_W'(1);
   end

   stat_event_decode #(.LEN_W(LEN_W), .NFLAG(RX_FLAGS), .BAD_MASK(RX_BAD_MASK)) i_rx_dec (
      .evt(rx_evt), .len(rx_len), .cast(rx_cast), .flags(rx_fcs_err), .inc(rx_inc)
   );
   stat_event_decode #(.LEN_W(LEN_W), .NFLAG(TX_FLAGS), .BAD_MASK(TX_BAD_MASK)) i_tx_dec (
      .evt(tx_evt), .len(tx_len), .cast(tx_cast), .flags(tx_flags), .inc(tx_inc)
   );

   for (genvar i = 0; i < RX_N; i++) begin : g_rx
      localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(RX_BASE + i);
      logic [LEN_W-1:0] amt;
      if (i == IDX_OCTET) begin : g_oct
         assign amt = rx_len;
      end else begin : g_one
         assign amt = LEN_W'(1);
      end
      stat_counter #(.CNT_W(CNT_W), .AMT_W(LEN_W)) i_cnt (
         .clk(clk), .rst_n(rst_n), .clr(clr_all),
         .wr(bus_wr && bus_addr == A_CNT), .wdata(bus_wdata),
         .inc(rx_inc[i]), .amt(amt), .cnt(rx_cnt[i]), .msb_rise(rx_rise[i])
      );
   end

   for (genvar i = 0; i < TX_N; i++) begin : g_tx
      localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(TX_BASE + i);
      logic [LEN_W-1:0] amt;
      if (i == IDX_OCTET) begin : g_oct
         assign amt = tx_len;
      end else begin : g_one
         assign amt = LEN_W'(1);
      end
      stat_counter #(.CNT_W(CNT_W), .AMT_W(LEN_W)) i_cnt (
         .clk(clk), .rst_n(rst_n), .clr(clr_all),
         .wr(bus_wr && bus_addr == A_CNT), .wdata(bus_wdata),
         .inc(tx_inc[i]), .amt(amt), .cnt(tx_cnt[i]), .msb_rise(tx_rise[i])
      );
   end

   stat_irq_reg #(.N(RX_N)) i_rx_irq (
      .clk(clk), .rst_n(rst_n), .set(rx_rise),
      .wr_st(bus_wr && bus_addr == A_RX_ST), .wr_en(bus_wr && bus_addr == A_RX_EN),
      .wdata(bus_wdata[RX_N-1:0]), .st(rx_st), .en(rx_en), .irq(rx_irq)
   );
   stat_irq_reg #(.N(TX_N)) i_tx_irq (
      .clk(clk), .rst_n(rst_n), .set(tx_rise),
      .wr_st(bus_wr && bus_addr == A_TX_ST), .wr_en(bus_wr && bus_addr == A_TX_EN),
      .wdata(bus_wdata[TX_N-1:0]), .st(tx_st), .en(tx_en), .irq(tx_irq)
   );

   assign irq = rx_irq | tx_irq;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL:  bus_rdata = ctrl_q;
         A_RX_ST: bus_rdata = CNT_W'(rx_st);
         A_RX_EN: bus_rdata = CNT_W'(rx_en);
         A_TX_ST: bus_rdata = CNT_W'(tx_st);
         A_TX_EN: bus_rdata = CNT_W'(tx_en);
         default: bus_rdata = '0;
      endcase
      for (int i = 0; i < RX_N; i++)
         if (bus_addr == ADDR_W'(RX_BASE + i)) bus_rdata = rx_cnt[i];
      for (int i = 0; i < TX_N; i++)
         if (bus_addr == ADDR_W'(TX_BASE + i)) bus_rdata = tx_cnt[i];
   end
endmodule

// File: rtl/stat_counter_bank_chk.sv
module stat_counter_bank_chk #(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 8,
   parameter int RX_N   = 13,
   parameter int TX_N   = 19,
   parameter int RX_BASE = 32
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [ADDR_W-1:0]          bus_addr,
   input logic                       bus_wr,
   input logic [CNT_W-1:0]           bus_wdata,
   input logic                       rd_lsb,
   input logic                       irq,
   input logic [RX_N-1:0][CNT_W-1:0] rx_cnt,
   input logic [TX_N-1:0][CNT_W-1:0] tx_cnt,
   input logic                       all_inc,
   input logic                       good_st,
   input logic [RX_N-1:0]            rx_en,
   input logic [TX_N-1:0]            tx_en
);
   import stat_pkg::*;

   a_r1_ctrl_lsb_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == '0) |-> !rd_lsb);

   a_r2_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == '0 && bus_wdata[0]) |=> (rx_cnt == '0 && tx_cnt == '0));

   a_r3_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(RX_BASE)) |=> (rx_cnt[IDX_GOOD] == $past(bus_wdata)));

   a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && all_inc && rx_cnt[IDX_ALL] == '1) |=> (rx_cnt[IDX_ALL] == '0));

   a_r8_status_on_msb_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_cnt[IDX_GOOD][CNT_W-1]) |-> good_st);

   a_r9_no_irq_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en == '0 && tx_en == '0) |-> !irq);
endmodule

bind stat_counter_bank stat_counter_bank_chk #(
   .CNT_W(CNT_W), .ADDR_W(ADDR_W), .RX_N(RX_N), .TX_N(TX_N), .RX_BASE(RX_BASE)
) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .rd_lsb(bus_rdata[0]), .irq(irq),
   .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .all_inc(rx_inc[stat_pkg::IDX_ALL]),
   .good_st(rx_st[stat_pkg::IDX_GOOD]), .rx_en(rx_en), .tx_en(tx_en)
);

// File: tb/test_stat_counter_bank.sv
module test_stat_counter_bank;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_evt = 1'b0;
   logic [15:0] rx_len = '0;
   logic [1:0]  rx_cast = '0;
   logic        rx_fcs_err = 1'b0;
   logic        tx_evt = 1'b0;
   logic [15:0] tx_len = '0;
   logic [1:0]  tx_cast = '0;
   logic [6:0]  tx_flags = '0;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stat_counter_bank i_stat_counter_bank (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_evt(rx_evt), .rx_len(rx_len), .rx_cast(rx_cast), .rx_fcs_err(rx_fcs_err),
      .tx_evt(tx_evt), .tx_len(tx_len), .tx_cast(tx_cast), .tx_flags(tx_flags),
      .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic rd_check(input string req, input logic [7:0] addr, input logic [31:0] exp);
      bus_addr = addr;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic wr(input logic [7:0] addr, input logic [31:0] data);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rx_frame(input int len, input logic [1:0] cast, input logic fcs);
      @(negedge clk);
      rx_evt = 1'b1; rx_len = 16'(len); rx_cast = cast; rx_fcs_err = fcs;
      @(negedge clk);
      rx_evt = 1'b0; rx_fcs_err = 1'b0;
   endtask

   task automatic tx_frame(input int len, input logic [1:0] cast, input logic [6:0] flags);
      @(negedge clk);
      tx_evt = 1'b1; tx_len = 16'(len); tx_cast = cast; tx_flags = flags;
      @(negedge clk);
      tx_evt = 1'b0; tx_flags = '0;
   endtask

   task automatic t_reset;
      rd_check("R1 ctrl reset", 8'h00, 32'h0000000A);
      rd_check("R3 counter reset", 8'h20, 32'h0);
      rd_check("R10 unmapped", 8'h10, 32'h0);
      check("R9 irq reset", 32'(irq), 32'h0);
   endtask

   task automatic t_rx_basic;
      rx_frame(64, 2'd0, 1'b0);
      rd_check("R5 rx good", 8'h20, 1);
      rd_check("R5 rx octets", 8'h21, 64);
      rd_check("R5 rx unicast", 8'h22, 1);
      rd_check("R5 rx all", 8'h25, 1);
      rd_check("R6 rx bin64", 8'h26, 1);
      rd_check("R6 rx bin127", 8'h27, 0);
      rx_frame(100, 2'd1, 1'b1);
      rd_check("R5 rx all after bad", 8'h25, 2);
      rd_check("R7 rx fcs", 8'h2C, 1);
      rd_check("R5 rx good unchanged", 8'h20, 1);
      rd_check("R5 rx multicast bad ignored", 8'h23, 0);
      rd_check("R6 rx bin127 bad ignored", 8'h27, 0);
   endtask

   task automatic t_tx_bins;
      tx_frame(40, 2'd2, '0);
      tx_frame(127, 2'd2, '0);
      tx_frame(128, 2'd2, '0);
      tx_frame(255, 2'd2, '0);
      tx_frame(256, 2'd2, '0);
      tx_frame(1023, 2'd2, '0);
      tx_frame(1024, 2'd2, '0);
      tx_frame(1500, 2'd2, '0);
      rd_check("R6 tx bin64", 8'h46, 0);
      rd_check("R6 tx bin127", 8'h47, 1);
      rd_check("R6 tx bin255", 8'h48, 2);
      rd_check("R6 tx bin511", 8'h49, 1);
      rd_check("R6 tx bin1023", 8'h4A, 1);
      rd_check("R6 tx binbig", 8'h4B, 2);
      rd_check("R5 tx broadcast", 8'h44, 8);
      rd_check("R5 tx octets", 8'h41, 4353);
   endtask

   task automatic t_tx_flags;
      tx_frame(64, 2'd0, 7'b0000001);
      rd_check("R7 tx single collision", 8'h4C, 1);
      rd_check("R7 tx good with collision", 8'h40, 9);
      tx_frame(64, 2'd0, 7'b0000100);
      rd_check("R7 tx late collision", 8'h4E, 1);
      rd_check("R7 tx good not after late", 8'h40, 9);
      tx_frame(64, 2'd0, 7'b1000000);
      rd_check("R7 tx abort", 8'h52, 1);
      rd_check("R7 tx all", 8'h45, 11);
      rd_check("R5 tx unicast only good", 8'h42, 1);
   endtask

   task automatic t_write;
      wr(8'h20, 32'h1234);
      rd_check("R3 write readback", 8'h20, 32'h1234);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 8'h20; bus_wdata = 32'd5;
      rx_evt = 1'b1; rx_len = 16'd64; rx_cast = 2'd0; rx_fcs_err = 1'b0;
      @(negedge clk);
      bus_wr = 1'b0; rx_evt = 1'b0;
      rd_check("R3 write beats increment", 8'h20, 5);
      rd_check("R3 other counter increments", 8'h25, 3);
   endtask

   task automatic t_wrap_irq;
      wr(8'h25, 32'hFFFFFFFF);
      rx_frame(64, 2'd0, 1'b0);
      rd_check("R4 wrap", 8'h25, 0);
      rd_check("R8 rx status from msb rise", 8'h01, 32'h20);
      check("R9 irq masked", 32'(irq), 0);
      wr(8'h01, 32'h20);
      rd_check("R8 rx status w1c", 8'h01, 0);
      wr(8'h41, 32'h7FFFFFFF);
      tx_frame(1, 2'd2, '0);
      rd_check("R4 tx octets carry", 8'h41, 32'h80000000);
      rd_check("R8 tx status", 8'h03, 32'h2);
      check("R9 irq still masked", 32'(irq), 0);
      wr(8'h04, 32'h2);
      rd_check("R9 enable readback", 8'h04, 32'h2);
      check("R9 irq asserted", 32'(irq), 1);
      wr(8'h03, 32'h1);
      rd_check("R8 w1c zero bit no effect", 8'h03, 32'h2);
      wr(8'h03, 32'h2);
      rd_check("R8 tx status cleared", 8'h03, 0);
      check("R9 irq deasserted", 32'(irq), 0);
   endtask

   task automatic t_clear;
      wr(8'h00, 32'h0000000B);
      rd_check("R1 ctrl bit0 reads zero", 8'h00, 32'h0000000A);
      rd_check("R2 rx good cleared", 8'h20, 0);
      rd_check("R2 tx octets cleared", 8'h41, 0);
      rd_check("R2 tx all cleared", 8'h45, 0);
      wr(8'h00, 32'h4);
      rd_check("R1 ctrl plain bits", 8'h00, 32'h4);
      rx_frame(64, 2'd0, 1'b0);
      rd_check("R2 counters live after clear", 8'h25, 1);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h1;
      rx_evt = 1'b1; rx_len = 16'd64; rx_cast = 2'd0;
      @(negedge clk);
      bus_wr = 1'b0; rx_evt = 1'b0;
      rd_check("R2 clear beats increment", 8'h25, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rx_basic();
      t_tx_bins();
      t_tx_flags();
      t_write();
      t_wrap_irq();
      t_clear();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule